// File: doc/BRIEF.md
# Broadcast Audio Packet Filter

The filter runs on the receive side of an Ethernet link. A receive MAC hands it one 32-bit word per cycle, marked by a valid strobe. It also delivers an end-of-packet pulse that reports either a good CRC or a failed CRC. The filter checks the first four words of each packet against a fixed broadcast audio header. It counts the words that follow and passes only the PCM sample words of a conforming packet to a write-side sample port. That port would normally feed a clock-crossing FIFO.

A nonconforming packet never reaches the sample port again once the fault is seen. This covers a header mismatch, excess length and a failed CRC. The filter keeps discarding words until that packet's end pulse arrives. Some samples can still go out before the fault becomes visible, for example when a packet is too short or its CRC fails. For that reason every end pulse is followed by exactly one verdict pulse. A commit pulse tells the downstream buffer to keep the samples it has received. A discard pulse tells it to roll them back.

Top module: `audio_pkt_filter`

## Requirements
- R1: While `rst_ni` is low, `sample_we_o`, `commit_o` and `discard_o` are 0. After reset, parsing starts at word index 0.
- R2: Word index 0 must equal 0xFFFFFFFF, index 1 must equal 0xFFFF0090 and index 2 must equal 0xC2001C50. Any mismatch causes every later word of that packet to be withheld from the sample port, and the packet ends with a discard.
- R3: For word index 3, bits [31:16] must equal 0x0101, and a mismatch there is handled the same way as in R2. Bits [15:0] of index 3 are ignored.
- R4: A word with index 4 through 4+`PAYLOAD_WORDS`-1 is a sample word. If no fault has been seen earlier in its packet, `sample_we_o` is high for one cycle in the cycle after the word is accepted, with `sample_o` equal to that word.
- R5: Header words (index 0 to 3) never raise `sample_we_o`.
- R6: A packet that ends with fewer than 4+`PAYLOAD_WORDS` words is answered with a discard pulse.
- R7: In a packet longer than 4+`PAYLOAD_WORDS` words, the first excess word and every word after it are never forwarded, and the packet is answered with a discard pulse.
- R8: A packet whose end is flagged by `end_bad_i` is always answered with a discard pulse, never a commit pulse. This also holds when `end_good_i` is high in the same cycle.
- R9: Every end pulse produces exactly one one-cycle verdict in the next cycle. The verdict is `commit_o` only for a fault-free packet of exactly 4+`PAYLOAD_WORDS` words that ends on `end_good_i`; otherwise it is `discard_o`. No verdict appears without an end pulse.
- R10: A valid word in the same cycle as an end pulse counts as the last word of the current packet. The word after an end pulse is index 0 of a new packet, and no fault carries over into it.
- R11: Cycles with `word_valid_i` low are ignored: no forwarding, no index advance, whatever `word_i` holds.
- R12: The word index saturates, so a packet many times longer than the counter's range is still discarded and never forwards a word past the payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Ethernet-side clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| word_i | input | 32 | Received packet word |
| word_valid_i | input | 1 | `word_i` is valid this cycle |
| end_good_i | input | 1 | End of packet, CRC good |
| end_bad_i | input | 1 | End of packet, CRC failed |
| sample_o | output | 32 | Forwarded PCM sample |
| sample_we_o | output | 1 | Write strobe for `sample_o` |
| commit_o | output | 1 | Keep the samples of the packet that just ended |
| discard_o | output | 1 | Roll back the samples of the packet that just ended |

## Verification
The bench builds the filter with `PAYLOAD_WORDS` = 8, so a conforming packet is 12 words long. The index counter is then only 4 bits wide. With packets this short, hundreds of them fit into the run: every header word can be faulted, and lengths one short and one long can be tried. A 40-word packet overruns the 4-bit counter range several times, so saturation is tested directly rather than only argued.

// File: rtl/apf_pkg.sv
package apf_pkg;
  localparam int DATA_W    = 32;
  localparam int HDR_WORDS = 4;
  // header word k sits at [k*DATA_W +: DATA_W]
  localparam logic [HDR_WORDS*DATA_W-1:0] HDR_EXP  =
    {32'h0101_0000, 32'hC200_1C50, 32'hFFFF_0090, 32'hFFFF_FFFF};
  localparam logic [HDR_WORDS*DATA_W-1:0] HDR_MASK =
    {32'hFFFF_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF};
endpackage

// File: rtl/apf_word_counter.sv
module apf_word_counter #(
  parameter int LIMIT = 1028,
  parameter int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             clear_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q;

  always_comb cnt_nxt_o = (step_i && cnt_q != LIMIT_C) ? cnt_q + 1'b1 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else              cnt_q <= cnt_nxt_o;
  end

  assign cnt_o = cnt_q;

  a_r12_cnt_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIMIT_C);
endmodule

// File: rtl/apf_hdr_check.sv
module apf_hdr_check
  import apf_pkg::*;
#(
  parameter int IDX_W = 11
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              in_hdr_o,
  output logic              mismatch_o
);
  logic [HDR_WORDS-1:0] hit;
  logic [HDR_WORDS-1:0] diff;

  for (genvar k = 0; k < HDR_WORDS; k++) begin : g_cmp
    assign hit[k]  = (idx_i == IDX_W'(k));
    assign diff[k] = ((word_i ^ HDR_EXP[k*DATA_W +: DATA_W])
                      & HDR_MASK[k*DATA_W +: DATA_W]) != '0;
  end

  assign in_hdr_o   = |hit;
  assign mismatch_o = |(hit & diff);
endmodule

// File: rtl/apf_verdict.sv
module apf_verdict #(
  parameter int TOTAL = 1028,
  parameter int CNT_W = $clog2(TOTAL + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             end_good_i,
  input  logic             end_bad_i,
  input  logic             fault_i,   // fault state including this cycle's word
  input  logic [CNT_W-1:0] len_i,     // length including this cycle's word
  output logic             commit_o,
  output logic             discard_o
);
  logic keep, end_any;

  assign end_any = end_good_i | end_bad_i;
  assign keep    = end_good_i & ~end_bad_i & ~fault_i & (len_i == CNT_W'(TOTAL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      commit_o  <= 1'b0;
      discard_o <= 1'b0;
    end else begin
      commit_o  <= keep;
      discard_o <= end_any & ~keep;
    end
  end

  a_r9_single_verdict: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(commit_o && discard_o));
  a_r8_bad_end_discards: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_bad_i |=> (discard_o && !commit_o));
endmodule

// File: rtl/audio_pkt_filter.sv
module audio_pkt_filter
  import apf_pkg::*;
#(
  parameter int PAYLOAD_WORDS = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       word_i,
  input  logic              word_valid_i,
  input  logic              end_good_i,
  input  logic              end_bad_i,
  output logic [31:0]       sample_o,
  output logic              sample_we_o,
  output logic              commit_o,
  output logic              discard_o
);
  localparam int TOTAL = HDR_WORDS + PAYLOAD_WORDS;
  localparam int CNT_W = $clog2(TOTAL + 1);

  logic [CNT_W-1:0] idx, idx_nxt;
  logic             end_any, in_hdr, hdr_miss;
  logic             excess, fault_q, fault_nxt, fwd;

  assign end_any = end_good_i | end_bad_i;

  apf_word_counter #(.LIMIT(TOTAL), .CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (word_valid_i),
    .clear_i  (end_any),
    .cnt_o    (idx),
    .cnt_nxt_o(idx_nxt)
  );

  apf_hdr_check #(.IDX_W(CNT_W)) u_hdr (
    .idx_i     (idx),
    .word_i    (word_i),
    .in_hdr_o  (in_hdr),
    .mismatch_o(hdr_miss)
  );

  // counter saturated at TOTAL means this word is beyond the payload
  assign excess    = word_valid_i & (idx == CNT_W'(TOTAL));
  assign fault_nxt = fault_q | (word_valid_i & hdr_miss) | excess;
  assign fwd       = word_valid_i & ~fault_q & ~in_hdr & (idx < CNT_W'(TOTAL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      fault_q <= 1'b0;
    else if (end_any) fault_q <= 1'b0;
    else              fault_q <= fault_nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_we_o <= 1'b0;
      sample_o    <= '0;
    end else begin
      sample_we_o <= fwd;
      if (fwd) sample_o <= word_i;
    end
  end

  apf_verdict #(.TOTAL(TOTAL), .CNT_W(CNT_W)) u_verdict (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .end_good_i(end_good_i),
    .end_bad_i (end_bad_i),
    .fault_i   (fault_nxt),
    .len_i     (idx_nxt),
    .commit_o  (commit_o),
    .discard_o (discard_o)
  );

  a_r9_verdict_after_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_any |=> (commit_o ^ discard_o));
  a_r9_no_spurious_verdict: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_o || discard_o) |-> $past(end_any));
  a_r11_idle_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_valid_i |=> !sample_we_o);
  a_r5_no_header_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_i && idx < CNT_W'(HDR_WORDS)) |=> !sample_we_o);
  a_r7_no_excess_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_i && idx == CNT_W'(TOTAL)) |=> !sample_we_o);
  a_r4_sample_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_we_o |-> $stable(sample_o));
endmodule

// File: tb/audio_pkt_filter_bench.sv
module audio_pkt_filter_bench;
  localparam int PAY = 8;
  localparam int TOT = 4 + PAY;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] word = '0;
  logic        valid = 1'b0, eg = 1'b0, eb = 1'b0;
  logic [31:0] sample;
  logic        we, commit, discard;

  int checks = 0, errors = 0;
  int m_idx = 0;
  bit m_bad = 0;

  always #4 clk = ~clk;

  audio_pkt_filter #(.PAYLOAD_WORDS(PAY)) u_audio_pkt_filter (
    .clk_i(clk), .rst_ni(rst_ni), .word_i(word), .word_valid_i(valid),
    .end_good_i(eg), .end_bad_i(eb), .sample_o(sample), .sample_we_o(we),
    .commit_o(commit), .discard_o(discard)
  );

  function automatic logic [31:0] hdr_word(int k, logic [15:0] pad);
    case (k)
      0: return 32'hFFFF_FFFF;
      1: return 32'hFFFF_0090;
      2: return 32'hC200_1C50;
      default: return {16'h0101, pad};
    endcase
  endfunction

  function automatic bit hdr_good(int k, logic [31:0] d);
    if (k == 3) return d[31:16] == 16'h0101;
    return d == hdr_word(k, 16'h0);
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cycle(bit v, logic [31:0] d, bit g, bit b, string tag);
    bit exp_we, exp_c, exp_d;
    @(negedge clk);
    valid = v; word = d; eg = g; eb = b;
    exp_we = 0; exp_c = 0; exp_d = 0;
    if (v) begin
      exp_we = !m_bad && m_idx >= 4 && m_idx < TOT;
      if (m_idx < 4 && !hdr_good(m_idx, d)) m_bad = 1;
      if (m_idx >= TOT) m_bad = 1;
      m_idx++;
    end
    if (g || b) begin
      exp_c = g && !b && !m_bad && m_idx == TOT;
      exp_d = !exp_c;
      m_idx = 0; m_bad = 0;
    end
    @(posedge clk); #1;
    chk(we == exp_we, tag, "sample_we", 32'(we), 32'(exp_we));
    if (exp_we) chk(sample == d, tag, "sample data", sample, d);
    chk(commit == exp_c, tag, "commit", 32'(commit), 32'(exp_c));
    chk(discard == exp_d, tag, "discard", 32'(discard), 32'(exp_d));
  endtask

  // bad_at: header index to corrupt, -1 for none
  task automatic send_pkt(int n, int bad_at, bit crc_bad, bit end_sep, int gap_pct, string tag);
    for (int i = 0; i < n; i++) begin
      logic [31:0] w;
      bit last;
      while (int'($urandom % 100) < gap_pct) cycle(0, $urandom, 0, 0, tag);
      w = (i < 4) ? hdr_word(i, 16'($urandom)) : $urandom;
      if (i == bad_at) w ^= (i == 3) ? 32'h0001_0000 : 32'h0000_0100;
      last = (i == n - 1) && !end_sep;
      cycle(1, w, last && !crc_bad, last && crc_bad, tag);
    end
    if (end_sep || n == 0) cycle(0, $urandom, !crc_bad, crc_bad, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    chk(we == 0 && commit == 0 && discard == 0, "R1", "outputs in reset",
        {29'd0, we, commit, discard}, 32'd0);
    @(negedge clk); rst_ni = 1'b1;

    send_pkt(TOT, -1, 0, 0, 0,  "R4 conforming");
    send_pkt(TOT, -1, 0, 1, 30, "R11 gaps end separate");
    send_pkt(TOT, -1, 0, 0, 50, "R11 heavy gaps");
    // padding variations
    cycle(1, hdr_word(0, 0), 0, 0, "R3 pad");
    cycle(1, hdr_word(1, 0), 0, 0, "R3 pad");
    cycle(1, hdr_word(2, 0), 0, 0, "R3 pad");
    cycle(1, {16'h0101, 16'hFFFF}, 0, 0, "R3 pad ignored");
    for (int i = 0; i < PAY; i++) cycle(1, $urandom, i == PAY - 1, 0, "R3 pad ignored");
    for (int k = 0; k < 3; k++) send_pkt(TOT, k, 0, 0, 10, "R2 header mismatch");
    send_pkt(TOT, 3, 0, 0, 10, "R3 type mismatch");
    send_pkt(TOT - 1, -1, 0, 0, 0, "R6 one short");
    send_pkt(3, -1, 0, 0, 0, "R6 inside header");
    send_pkt(0, -1, 0, 0, 0, "R6 empty");
    send_pkt(TOT + 1, -1, 0, 0, 0, "R7 one long");
    send_pkt(40, -1, 0, 1, 20, "R12 saturating long");
    send_pkt(TOT, -1, 1, 0, 0, "R8 crc bad");
    send_pkt(TOT, -1, 1, 1, 0, "R8 crc bad separate");
    cycle(1, hdr_word(0, 0), 1, 1, "R8 both pulses");
    send_pkt(TOT, 1, 0, 0, 0, "R10 fault before");
    send_pkt(TOT, -1, 0, 0, 0, "R10 clean after fault");
    for (int p = 0; p < 120; p++) begin
      int sel, n, bad_at;
      sel = $urandom % 8;
      n = TOT; bad_at = -1;
      if (sel == 1) n = $urandom % (TOT + 6);
      if (sel == 2) bad_at = $urandom % 4;
      send_pkt(n, bad_at, sel == 3, $urandom % 2, $urandom % 40, "R9 random");
    end
    cycle(0, 0, 0, 0, "R11 idle tail");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule